// File: doc/BRIEF.md
# Instruction Cache Set Parity Scanner

This block audits one set of a four-way instruction cache after a cache error has been reported. Software or a recovery controller gives it a set index and a start pulse. The scanner then fetches each way's tag record, and when asked also that way's four data records, over a simple request/acknowledge read port. The port is served by whatever logic can reach the cache arrays.

Every record carries its own parity protection:

- **Tag record.** The way's valid flag has a duplicate bit. The low tag word is split into two parity domains.
- **Data record.** The predecode byte has one parity bit. Each of the two 32-bit instructions has a nibble of even byte parity.

The scanner folds all mismatches into two sticky flags, tag-parity and data-parity, and into a per-way error vector. It also captures the valid bit of each way and the set's LRU ordering. It then signals completion with a single-cycle done pulse.

Top module: `ic_set_parity_scan`

## Requirements
- R1: After start, the read requests are issued in this order: way 0 to way 3, and within each way the tag record first, then data offsets 0, 1, 2, 3. The request address is (way << 13) | setIndex for a tag record (rdKind = 0) and (way << 13) | setIndex | (offset << 3) for a data record (rdKind = 1).
- R2: Only one read is ever outstanding. Once rdReq is raised, it stays high with rdAddr and rdKind unchanged until a cycle in which rdAck is high; the response on rdHi/rdLo is taken in that same cycle.
- R3: Tag-high bit 29 is the way's valid flag and bit 27 is its duplicate. Any disagreement between them sets the tag-parity flag, whether or not the way is valid.
- R4: For a valid way, tag-low bit 10 must equal the XOR of tag-low bits 23:0 excluding bits 11 and 10. A mismatch sets the tag-parity flag, and for an invalid way it is ignored.
- R5: For a valid way, tag-low bit 11 must equal the XOR of tag-low bits 63:24. A mismatch sets the tag-parity flag, and for an invalid way it is ignored.
- R6: In a data record, data-high bit 16 must equal the XOR of the predecode byte in data-high bits 15:8. A mismatch sets the data-parity flag.
- R7: Instruction A is rdLo[63:32] and instruction B is rdLo[31:0]. Their parity nibbles are data-high bits 7:4 and 3:0. Nibble bit 3 is the even parity of the instruction's byte 31:24, down to nibble bit 0 for byte 7:0. Any mismatch sets the data-parity flag.
- R8: With dataCheck low at start, no data record is requested (four reads in total), and data corruption cannot set any flag.
- R9: wayValid[w] reports tag-high bit 29 of way w. lruOrder reports tag-high bits 21:14 of way 0, which hold four 2-bit way numbers with the least recently used way in bits 1:0.
- R10: wayErr[w] is set when any tag or data check of way w fails. It is never set without one of the two flags.
- R11: Flags, wayErr, wayValid and lruOrder clear when a start is accepted, and hold their values until the next accepted start.
- R12: done is high for exactly one cycle, in the cycle after the last record's acknowledge. A start pulse while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| setIndex | input | 13 | Set index ORed into every read address |
| dataCheck | input | 1 | Also read and check the data records |
| rdReq | output | 1 | Read request |
| rdKind | output | 1 | 0 = tag record, 1 = data record |
| rdAddr | output | 15 | Read address |
| rdAck | input | 1 | Response valid, completes the request |
| rdHi | input | 32 | Tag-high or data-high word |
| rdLo | input | 64 | Tag-low word or the two instructions |
| done | output | 1 | One-cycle completion pulse |
| tagErr | output | 1 | Sticky tag-parity error |
| dataErr | output | 1 | Sticky data-parity error |
| wayErr | output | 4 | Per-way error vector |
| wayValid | output | 4 | Valid flag of each way |
| lruOrder | output | 8 | LRU ordering read from way 0 |

## Verification
The hardest situations to reach are the invalid-way cases. There, a broken tag-low parity must be ignored while a broken duplicate valid bit must still be reported, and only the port flags reveal which rule was applied. The bench's read responder serves records from a small model of the set. Each scenario builds clean records with correct parity and then flips one chosen bit in one chosen way, record or offset. The scenarios also vary the acknowledge latency, and they inject a second start pulse in the middle of a scan, so that the hold and ignore rules are exercised while a request is pending.

// File: rtl/ic_scan_pkg.sv
package ic_scan_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFFS  = 4;
  localparam int OFF_W = $clog2(OFFS);

  // tag-high field positions
  localparam int VALID_BIT  = 29;
  localparam int VALID_DUP  = 27;
  localparam int LRU_LSB    = 14;
  localparam int LRU_W      = 2 * WAYS;
  // tag-low parity positions
  localparam int TLO_P0_BIT = 10;
  localparam int TLO_P1_BIT = 11;
  localparam logic [23:0] TLO_P0_MASK = 24'hFFF3FF;
  // data-high field positions
  localparam int PRE_LSB    = 8;
  localparam int PRE_PAR    = 16;

  typedef struct packed {
    logic             clear;
    logic             tagStb;
    logic             dataStb;
    logic [WAY_W-1:0] way;
  } scanStrobe_t;

  function automatic logic [3:0] byteParity(input logic [31:0] word);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^word[8*b +: 8];
    return p;
  endfunction
endpackage

// File: rtl/ic_scan_ctrl.sv
module ic_scan_ctrl
  import ic_scan_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int ADDR_W = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  setIndex,
  input  logic              dataCheck,
  input  logic              rdAck,
  output logic              rdReq,
  output logic              rdKind,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done,
  output scanStrobe_t       strb
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE} scanState_t;

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(OFFS - 1);

  scanState_t       state;
  logic [WAY_W-1:0] wayIdx;
  logic [OFF_W-1:0] offIdx;
  logic             isData;
  logic             dataEnQ;
  logic [IDX_W-1:0] idxQ;
  logic             lastRec;
  logic             accept;

  assign accept  = (state == S_REQ) && rdAck;
  assign lastRec = (wayIdx == LAST_WAY) &&
                   (isData ? (offIdx == LAST_OFF) : !dataEnQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wayIdx  <= '0;
      offIdx  <= '0;
      isData  <= 1'b0;
      dataEnQ <= 1'b0;
      idxQ    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          wayIdx  <= '0;
          offIdx  <= '0;
          isData  <= 1'b0;
          dataEnQ <= dataCheck;
          idxQ    <= setIndex;
        end
        S_REQ: if (rdAck) begin
          if (lastRec) begin
            state <= S_DONE;
          end else if (!isData && dataEnQ) begin
            isData <= 1'b1;
            offIdx <= '0;
          end else if (isData && offIdx != LAST_OFF) begin
            offIdx <= offIdx + 1'b1;
          end else begin
            isData <= 1'b0;
            offIdx <= '0;
            wayIdx <= wayIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rdReq  = (state == S_REQ);
    rdKind = isData;
    rdAddr = {wayIdx, {IDX_W{1'b0}}} | ADDR_W'(idxQ);
    if (isData) rdAddr = rdAddr | (ADDR_W'(offIdx) << 3);
    done         = (state == S_DONE);
    strb.clear   = (state == S_IDLE) && start;
    strb.tagStb  = accept && !isData;
    strb.dataStb = accept && isData;
    strb.way     = wayIdx;
  end

  // R2: a pending request keeps its address and kind until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr) && $stable(rdKind));
  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R1: the scan always opens with a tag read of way 0
  p_first_tag_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> rdReq && !rdKind && rdAddr[ADDR_W-1 -: WAY_W] == '0);
  // R12: a start arriving mid-scan does not restart the walk
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && start && !rdAck |=> $stable(rdAddr));
endmodule

// File: rtl/ic_scan_datapath.sv
module ic_scan_datapath
  import ic_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strb,
  input  logic [31:0]      rdHi,
  input  logic [63:0]      rdLo,
  output logic             tagErr,
  output logic             dataErr,
  output logic [WAYS-1:0]  wayErr,
  output logic [WAYS-1:0]  wayValid,
  output logic [LRU_W-1:0] lruOrder
);
  logic validBit;
  logic validDupBad;
  logic tagLowBad;
  logic tagHighBad;
  logic tagBad;
  logic preBad;
  logic instABad;
  logic instBBad;
  logic dataBad;

  always_comb begin
    validBit    = rdHi[VALID_BIT];
    validDupBad = validBit ^ rdHi[VALID_DUP];
    tagLowBad   = rdLo[TLO_P0_BIT] ^ (^(rdLo[23:0] & TLO_P0_MASK));
    tagHighBad  = rdLo[TLO_P1_BIT] ^ (^rdLo[63:24]);
    tagBad      = validDupBad || (validBit && (tagLowBad || tagHighBad));
    preBad      = rdHi[PRE_PAR] ^ (^rdHi[PRE_LSB +: 8]);
    instABad    = rdHi[7:4] != byteParity(rdLo[63:32]);
    instBBad    = rdHi[3:0] != byteParity(rdLo[31:0]);
    dataBad     = preBad || instABad || instBBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      tagErr   <= 1'b0;
      dataErr  <= 1'b0;
      wayErr   <= '0;
      wayValid <= '0;
      lruOrder <= '0;
    end else begin
      if (strb.tagStb) begin
        wayValid[strb.way] <= validBit;
        if (strb.way == '0) lruOrder <= rdHi[LRU_LSB +: LRU_W];
        if (tagBad) begin
          tagErr             <= 1'b1;
          wayErr[strb.way]   <= 1'b1;
        end
      end
      if (strb.dataStb && dataBad) begin
        dataErr            <= 1'b1;
        wayErr[strb.way]   <= 1'b1;
      end
    end
  end

  // R11: flags are clear the cycle after a start is accepted
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !tagErr && !dataErr && wayErr == '0);
  // R11: a raised flag stays up until the next start
  p_sticky_tag_r11: assert property (@(posedge clk) disable iff (!rstN)
    tagErr && !strb.clear |=> tagErr);
  p_sticky_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    dataErr && !strb.clear |=> dataErr);
  // R10: a way error never stands without a flag
  p_wayerr_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|wayErr) |-> (tagErr || dataErr));
  // R8: the data flag only rises on a data-record acknowledge
  p_data_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataErr && !strb.dataStb |=> !dataErr);
endmodule

// File: rtl/ic_set_parity_scan.sv
module ic_set_parity_scan
  import ic_scan_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int ADDR_W = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  setIndex,
  input  logic              dataCheck,
  output logic              rdReq,
  output logic              rdKind,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [31:0]       rdHi,
  input  logic [63:0]       rdLo,
  output logic              done,
  output logic              tagErr,
  output logic              dataErr,
  output logic [WAYS-1:0]   wayErr,
  output logic [WAYS-1:0]   wayValid,
  output logic [LRU_W-1:0]  lruOrder
);
  scanStrobe_t strb;

  ic_scan_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .setIndex(setIndex),
    .dataCheck(dataCheck), .rdAck(rdAck), .rdReq(rdReq), .rdKind(rdKind),
    .rdAddr(rdAddr), .done(done), .strb(strb)
  );

  ic_scan_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdHi(rdHi), .rdLo(rdLo),
    .tagErr(tagErr), .dataErr(dataErr), .wayErr(wayErr),
    .wayValid(wayValid), .lruOrder(lruOrder)
  );
endmodule

// File: tb/ic_set_parity_scan_test.sv
module ic_set_parity_scan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [12:0] setIndex = '0;
  logic        dataCheck = 1'b0;
  logic        rdReq, rdKind, rdAck = 1'b0;
  logic [14:0] rdAddr;
  logic [31:0] rdHi = '0;
  logic [63:0] rdLo = '0;
  logic        done, tagErr, dataErr;
  logic [3:0]  wayErr, wayValid;
  logic [7:0]  lruOrder;

  int checks = 0, errors = 0, cyc = 0, lat = 0, waitCnt = 0;
  int readCount = 0, doneCount = 0;
  logic [15:0] addrLog [0:31];

  logic [31:0] tHi [0:3];
  logic [63:0] tLo [0:3];
  logic [31:0] dHi [0:3][0:3];
  logic [63:0] dLo [0:3][0:3];

  always #5 clk = ~clk;

  ic_set_parity_scan uut (
    .clk(clk), .rstN(rstN), .start(start), .setIndex(setIndex),
    .dataCheck(dataCheck), .rdReq(rdReq), .rdKind(rdKind), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdHi(rdHi), .rdLo(rdLo), .done(done), .tagErr(tagErr),
    .dataErr(dataErr), .wayErr(wayErr), .wayValid(wayValid), .lruOrder(lruOrder)
  );

  // read responder with programmable latency
  always @(negedge clk) begin
    if (done) doneCount++;
    if (rdReq && rstN) begin
      if (waitCnt >= lat) begin
        rdAck = 1'b1;
        waitCnt = 0;
        if (readCount < 32) addrLog[readCount] = {rdKind, rdAddr};
        readCount++;
        if (!rdKind) begin
          rdHi = tHi[rdAddr[14:13]];
          rdLo = tLo[rdAddr[14:13]];
        end else begin
          rdHi = dHi[rdAddr[14:13]][rdAddr[4:3]];
          rdLo = dLo[rdAddr[14:13]][rdAddr[4:3]];
        end
      end else begin
        rdAck = 1'b0;
        waitCnt++;
      end
    end else begin
      rdAck = 1'b0;
      waitCnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bp(input logic [31:0] w);
    return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
  endfunction

  // clean records: correct parity everywhere
  task automatic fillClean(input logic [7:0] lru, input logic [3:0] valid);
    for (int w = 0; w < 4; w++) begin
      logic [63:0] lo;
      tHi[w] = 32'h0;
      tHi[w][29] = valid[w];
      tHi[w][27] = valid[w];
      if (w == 0) tHi[w][21:14] = lru;
      lo = 64'h9A3C_5E71_0000_0000 ^ (64'h1357_2468_ACE0_BDF1 * (w + 3));
      lo[10] = ^(lo[23:0] & 24'hFFF3FF);
      lo[11] = ^lo[63:24];
      tLo[w] = lo;
      for (int o = 0; o < 4; o++) begin
        logic [63:0] ins;
        logic [7:0]  pre;
        ins = 64'h0123_4567_89AB_CDEF * (w * 4 + o + 7);
        pre = 8'h5B + 8'(w * 13 + o * 5);
        dLo[w][o] = ins;
        dHi[w][o] = {15'h0, ^pre, pre, bp(ins[63:32]), bp(ins[31:0])};
      end
    end
  endtask

  task automatic runScan(input logic [12:0] idx, input bit dEn);
    int d0 = doneCount;
    int guard = 0;
    @(negedge clk);
    readCount = 0;
    setIndex = idx; dataCheck = dEn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneCount == d0 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk("R12 scan completes", (guard < 500) ? 1 : 0, 1);
  endtask

  task automatic testReset;
    chk("R11 reset tagErr", tagErr, 0);
    chk("R11 reset dataErr", dataErr, 0);
    chk("R12 reset done", done, 0);
    chk("R2 reset rdReq", rdReq, 0);
  endtask

  task automatic testTagOnly;
    int bad = 0;
    fillClean(8'hE1, 4'b1111);
    lat = 1;
    runScan(13'h0A40, 1'b0);
    chk("R8 tag-only read count", readCount, 4);
    for (int w = 0; w < 4; w++)
      if (addrLog[w] !== {1'b0, 2'(w), 13'h0A40}) bad++;
    chk("R1 tag-only address order", bad, 0);
    chk("R9 lru order", lruOrder, 8'hE1);
    chk("R9 way valid", wayValid, 4'hF);
    chk("R11 clean flags", {tagErr, dataErr, wayErr}, 0);
  endtask

  task automatic testFullClean;
    int bad = 0, n = 0;
    fillClean(8'h1B, 4'b1011);
    lat = 0;
    runScan(13'h1FE0, 1'b1);
    chk("R1 full read count", readCount, 20);
    for (int w = 0; w < 4; w++) begin
      if (addrLog[n] !== {1'b0, 2'(w), 13'h1FE0}) bad++;
      n++;
      for (int o = 0; o < 4; o++) begin
        if (addrLog[n] !== {1'b1, 2'(w), 13'h1FE0 | 13'(o << 3)}) bad++;
        n++;
      end
    end
    chk("R1 full address order", bad, 0);
    chk("R9 way valid mix", wayValid, 4'b1011);
    chk("R9 lru order", lruOrder, 8'h1B);
    chk("R6 clean data flags", {tagErr, dataErr}, 0);
    @(negedge clk);
    chk("R12 done low after pulse", done, 0);
  endtask

  task automatic testInvalidWay;
    fillClean(8'hE4, 4'b1101);
    tLo[1][10] = ~tLo[1][10];
    tLo[1][11] = ~tLo[1][11];
    lat = 2;
    runScan(13'h0100, 1'b0);
    chk("R4 invalid way parity ignored", {tagErr, wayErr}, 0);
    tHi[1][27] = 1'b1;
    runScan(13'h0100, 1'b0);
    chk("R3 dup valid mismatch on invalid way", tagErr, 1);
    chk("R10 way error vector", wayErr, 4'b0010);
    chk("R9 valid with bad dup", wayValid, 4'b1101);
  endtask

  task automatic testTagLow;
    fillClean(8'hE4, 4'hF);
    tLo[2][5] = ~tLo[2][5];
    lat = 0;
    runScan(13'h0020, 1'b0);
    chk("R4 tag low parity", {tagErr, dataErr}, 2'b10);
    chk("R10 way 2 flagged", wayErr, 4'b0100);
    fillClean(8'hE4, 4'hF);
    tLo[0][11] = ~tLo[0][11];
    tLo[0][10] = ~tLo[0][10];
    tLo[0][11] = ~tLo[0][11];
    runScan(13'h0020, 1'b0);
    chk("R4 parity bit itself flipped", wayErr, 4'b0001);
  endtask

  task automatic testTagHigh;
    fillClean(8'hE4, 4'hF);
    tLo[1][40] = ~tLo[1][40];
    runScan(13'h0040, 1'b0);
    chk("R5 tag high parity", tagErr, 1);
    chk("R10 way 1 flagged", wayErr, 4'b0010);
  endtask

  task automatic testPredecode;
    fillClean(8'hE4, 4'hF);
    dHi[3][2][16] = ~dHi[3][2][16];
    lat = 1;
    runScan(13'h0060, 1'b0);
    chk("R8 data corruption ignored when disabled", {tagErr, dataErr, wayErr}, 0);
    runScan(13'h0060, 1'b1);
    chk("R6 predecode parity", {tagErr, dataErr}, 2'b01);
    chk("R10 way 3 flagged", wayErr, 4'b1000);
  endtask

  task automatic testInstParity;
    fillClean(8'hE4, 4'hF);
    dLo[0][3][63] = ~dLo[0][3][63];
    dHi[0][3][7]  = ~dHi[0][3][7];
    lat = 0;
    runScan(13'h0080, 1'b1);
    chk("R7 msb byte maps to nibble bit 3 (A)", dataErr, 0);
    fillClean(8'hE4, 4'hF);
    dHi[2][1][0] = ~dHi[2][1][0];
    runScan(13'h0080, 1'b1);
    chk("R7 instruction B nibble", dataErr, 1);
    chk("R10 way 2 data error", wayErr, 4'b0100);
    fillClean(8'hE4, 4'hF);
    dLo[1][0][33] = ~dLo[1][0][33];
    runScan(13'h0080, 1'b1);
    chk("R7 instruction A data bit", wayErr, 4'b0010);
  endtask

  task automatic testStickyAndBusy;
    int d0;
    fillClean(8'hE4, 4'hF);
    tHi[3][27] = 1'b0;
    runScan(13'h00A0, 1'b0);
    chk("R11 error raised", tagErr, 1);
    fillClean(8'h93, 4'hF);
    lat = 2;
    d0 = doneCount;
    @(negedge clk);
    readCount = 0;
    setIndex = 13'h00A0; dataCheck = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 flags cleared on start", {tagErr, wayErr}, 0);
    repeat (7) @(negedge clk);
    setIndex = 13'h0000; dataCheck = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 400 && doneCount == d0; g++) @(negedge clk);
    chk("R12 start while busy ignored", readCount, 20);
    chk("R12 one done pulse", doneCount - d0, 1);
    chk("R9 lru from new scan", lruOrder, 8'h93);
    repeat (5) @(negedge clk);
    chk("R11 flags hold after done", {tagErr, dataErr}, 0);
    chk("R12 no extra done", doneCount - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTagOnly();
    testFullClean();
    testInvalidWay();
    testTagLow();
    testTagHigh();
    testPredecode();
    testInstParity();
    testStickyAndBusy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule